// File: doc/BRIEF.md
# Serial Address-then-Data Register Loader

This block is a three-wire programming port through which a microcontroller writes a small bank of control registers. The three pins are a serial data line, a serial clock and a select line. All three are sampled by a fast system clock through two-flop synchronisers, and edges are detected on the synchronised copies. Bits are shifted in on each rising serial-clock edge, most-significant bit first. Nothing is written until the select line falls.

Each register write takes two frames. An address frame is clocked with select held high. When select falls, the last eight received bits go into an address latch. A data frame is clocked with select low and is then closed by a select-high pulse during which the serial clock stays still, at either level. The falling edge of that pulse writes the received bits into the register named by the latched address. A frame must contain a minimum number of serial-clock rising edges, or its closing edge writes nothing. Two sticky flags are raised when a transfer breaks the rules: one for a serial-clock edge inside the closing pulse of a data frame, and one for a data write aimed at a register that does not exist.

Top module: `ser_cfg_loader`

## Requirements
- R1: Each rising serial-clock edge shifts one data bit into the shift register. The first bit sent of a frame becomes the most-significant received bit.
- R2: Registers and the address latch change only in response to a falling edge of the select line.
- R3: A frame whose first serial-clock edge occurs with select high is an address frame. Its select fall loads the last 8 received bits into `addr_o`.
- R4: A frame whose first serial-clock edge occurs with select low is a data frame. Its select fall writes the last 16 received bits into register k = `addr_o`, which is output on `regs_o[16k+15:16k]`. This holds whether the serial clock rests high or low during the closing select-high pulse.
- R5: A data frame of fewer than 16 bits writes its bits right-aligned into the register, with the upper bits cleared to zero.
- R6: A select fall that follows fewer than 4 rising serial-clock edges since the previous select fall writes neither the address latch nor any register.
- R7: A rising serial-clock edge while select is high, inside a data frame after its first edge, sets `proto_err_o` and cancels that frame's write. `proto_err_o` stays set until reset.
- R8: A data write while the latched address is 8 or higher changes no register and sets `addr_err_o`, which stays set until reset.
- R9: Reset clears all eight registers, the address latch and both error flags.
- R10: The address latch keeps its value across data frames, so several data frames write the same register without a new address frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_data | input | 1 | Serial data line |
| pin_sclk | input | 1 | Serial clock line |
| pin_sel | input | 1 | Select line: its level chooses the frame type, its falling edge commits |
| regs_o | output | 128 | Register bank; register k occupies bits 16k+15 down to 16k |
| addr_o | output | 8 | Latched address |
| proto_err_o | output | 1 | Sticky flag: serial-clock edge inside a data frame's closing pulse |
| addr_err_o | output | 1 | Sticky flag: data write to an address with no register |

## Verification
The hardest case to reach from the pins is a serial-clock edge that arrives while select is high in a data frame. It has to come after the data bits have been clocked with select low and before select falls, so that the write is cancelled and not merely made short. The stimulus task for data frames has a switch that toggles the serial clock inside the closing pulse from whichever level it rests at. The bench then checks that the target register kept its old value and that the sticky flag is still set after a later valid write. The count-limit case (R6) is reached with 3-bit frames of both kinds, and the boundary frame of exactly 4 bits sits in the vector table.

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader #(
  parameter int NREGS     = 8,
  parameter int DW        = 16,
  parameter int AW        = 8,
  parameter int MIN_EDGES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_data,
  input  logic                pin_sclk,
  input  logic                pin_sel,
  output logic [NREGS*DW-1:0] regs_o,
  output logic [AW-1:0]       addr_o,
  output logic                proto_err_o,
  output logic                addr_err_o
);

  localparam int SW = (DW > AW) ? DW : AW;
  localparam int CW = $clog2(SW + MIN_EDGES + 1);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [1:0] d_s;
  logic [2:0] k_s, e_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      d_s <= '0;
      k_s <= '0;
      e_s <= '0;
    end else begin
      d_s <= {d_s[0], pin_data};
      k_s <= {k_s[1:0], pin_sclk};
      e_s <= {e_s[1:0], pin_sel};
    end

  wire din     = d_s[1];
  wire sel_lvl = e_s[1];
  wire k_rise  = k_s[1] & ~k_s[2];
  wire en_fall = ~e_s[1] & e_s[2];

  logic [SW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic          frame_addr, abort;

  wire bad_edge = k_rise & ~en_fall & (cnt != '0) & ~frame_addr & sel_lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg      <= '0;
      cnt        <= '0;
      frame_addr <= 1'b0;
      abort      <= 1'b0;
    end else if (en_fall) begin
      shreg <= '0;
      cnt   <= '0;
      abort <= 1'b0;
    end else if (k_rise) begin
      shreg <= {shreg[SW-2:0], din};
      if (cnt != CMAX) cnt <= cnt + 1'b1;
      if (cnt == '0) frame_addr <= sel_lvl;
      if (bad_edge) abort <= 1'b1;
    end

  wire enough      = cnt >= CW'(MIN_EDGES);
  wire addr_ok     = {1'b0, addr_o} < (AW+1)'(NREGS);
  wire commit_addr = en_fall & enough & frame_addr;
  wire commit_data = en_fall & enough & ~frame_addr & ~abort;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_o      <= '0;
      proto_err_o <= 1'b0;
      addr_err_o  <= 1'b0;
    end else begin
      if (commit_addr) addr_o <= shreg[AW-1:0];
      if (bad_edge) proto_err_o <= 1'b1;
      if (commit_data && !addr_ok) addr_err_o <= 1'b1;
    end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) regs_o[g*DW +: DW] <= '0;
      else if (commit_data && addr_o == AW'(g)) regs_o[g*DW +: DW] <= shreg[DW-1:0];
  end

  a_r2_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !en_fall |=> $stable(regs_o) && $stable(addr_o));

  a_r6_min_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && cnt < CW'(MIN_EDGES)) |=> $stable(regs_o) && $stable(addr_o));

  a_r3_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    commit_addr |=> addr_o == $past(shreg[AW-1:0]));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);

  a_r7_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && abort) |=> $stable(regs_o));

  a_r8_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && !addr_ok) |=> $stable(regs_o));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_o |=> addr_err_o);

endmodule

// File: tb/ser_cfg_loader_tb_top.sv
module ser_cfg_loader_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, sen = 1'b0;
  logic [127:0] regs;
  logic [7:0] addr;
  logic perr, aerr;
  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] m_reg [8];
  logic [7:0] m_addr;

  always #2.5 clk = ~clk;

  ser_cfg_loader dut_i (.clk(clk), .rst_n(rst_n), .pin_data(sdata), .pin_sclk(sclk),
    .pin_sel(sen), .regs_o(regs), .addr_o(addr), .proto_err_o(perr), .addr_err_o(aerr));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // {is_addr, nbits[4:0], value[15:0]}
  localparam logic [21:0] VEC [10] = '{
    {1'b1, 5'd8,  16'h0003},
    {1'b0, 5'd16, 16'hA5C3},
    {1'b1, 5'd8,  16'h0000},
    {1'b0, 5'd16, 16'h1234},
    {1'b0, 5'd12, 16'h0ABC},
    {1'b1, 5'd8,  16'h0007},
    {1'b0, 5'd5,  16'h0015},
    {1'b1, 5'd10, 16'h0305},
    {1'b0, 5'd4,  16'h000F},
    {1'b0, 5'd16, 16'hFFFF}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_flat();
    logic [127:0] f;
    for (int k = 0; k < 8; k++) f[k*16 +: 16] = m_reg[k];
    return f;
  endfunction

  task automatic shift_bits(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i];
      sclk = 1'b0;
      tick(4);
      sclk = 1'b1;
      tick(4);
    end
  endtask

  task automatic addr_frame(logic [15:0] v, int n);
    sen = 1'b1;
    tick(4);
    shift_bits(v, n);
    sclk = 1'b0;
    tick(4);
    sen = 1'b0;
    tick(8);
  endtask

  task automatic data_frame(logic [15:0] v, int n, bit rest_high, bit glitch);
    sen = 1'b0;
    shift_bits(v, n);
    if (!rest_high) sclk = 1'b0;
    tick(4);
    sen = 1'b1;
    tick(4);
    if (glitch) begin
      sclk = ~sclk;
      tick(4);
      sclk = ~sclk;
      tick(4);
    end
    sen = 1'b0;
    tick(8);
    sclk = 1'b0;
    tick(4);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) m_reg[k] = '0;
    m_addr = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    check("R9 regs after reset", regs, '0);
    check("R9 addr after reset", {120'd0, addr}, '0);
    check("R9 flags after reset", {126'd0, perr, aerr}, '0);

    for (int v = 0; v < 10; v++) begin
      logic isa;
      int nb;
      logic [15:0] val;
      isa = VEC[v][21];
      nb  = int'(VEC[v][20:16]);
      val = VEC[v][15:0];
      if (isa) begin
        addr_frame(val, nb);
        m_addr = val[7:0];
        check("R3 R1 address latch", {120'd0, addr}, {120'd0, m_addr});
      end else begin
        data_frame(val, nb, 1'b0, 1'b0);
        m_reg[m_addr[2:0]] = val;
        check("R4 R5 R10 target register", {112'd0, regs[m_addr[2:0]*16 +: 16]},
              {112'd0, m_reg[m_addr[2:0]]});
      end
      check("R2 whole bank", regs, model_flat());
    end

    data_frame(16'h0007, 3, 1'b0, 1'b0);
    check("R6 short data frame", regs, model_flat());
    addr_frame(16'h0002, 3);
    check("R6 short address frame", {120'd0, addr}, {120'd0, m_addr});

    data_frame(16'h0042, 8, 1'b1, 1'b0);
    m_reg[5] = 16'h0042;
    check("R4 clock rests high in pulse", regs, model_flat());
    check("R7 no error on clean frame", {127'd0, perr}, '0);

    data_frame(16'h1111, 16, 1'b0, 1'b1);
    check("R7 aborted write", regs, model_flat());
    check("R7 error raised", {127'd0, perr}, 128'd1);
    data_frame(16'h2222, 16, 1'b1, 1'b1);
    check("R7 aborted write rest high", regs, model_flat());
    data_frame(16'h3333, 16, 1'b0, 1'b0);
    m_reg[5] = 16'h3333;
    check("R7 later write works", regs, model_flat());
    check("R7 error sticky", {127'd0, perr}, 128'd1);

    addr_frame(16'h0009, 8);
    m_addr = 8'h09;
    check("R8 address out of range latched", {120'd0, addr}, {120'd0, m_addr});
    check("R8 no flag before write", {127'd0, aerr}, '0);
    data_frame(16'hBEEF, 16, 1'b0, 1'b0);
    check("R8 bank unchanged", regs, model_flat());
    check("R8 flag raised", {127'd0, aerr}, 128'd1);
    addr_frame(16'h0001, 8);
    data_frame(16'h00C0, 16, 1'b0, 1'b0);
    m_reg[1] = 16'h00C0;
    check("R8 flag sticky", {127'd0, aerr}, 128'd1);
    check("R10 bank after recovery", regs, model_flat());

    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    check("R9 regs after second reset", regs, '0);
    check("R9 state after second reset", {118'd0, addr, perr, aerr}, '0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule